// File: doc/BRIEF.md
# Receive Frame-Synchronization Controller

This block sequences a receiver through three phases. While idle it only listens for energy on the channel. A signal-detect strobe opens a bounded synchronization window. In that window the synchronizer must report a start-of-frame before a programmable number of cycles runs out. If it does not, the controller drops back to listening.

After a start-of-frame the controller enters the decoding phase. Three activities run side by side there: data decoding, synchronization tracking and block-level reconfiguration. Decoding is paused while a reconfiguration is in progress. The phase ends on a frame-end strobe, or on a loss-of-sync indication from the tracking logic.

The detection and decoding algorithms are outside this block. It produces only the phase indications and the enables that start and stop those engines. All inputs are sampled on the rising clock edge, and every output reflects registered state.

Top module: `rx_frame_seq`

## Requirements
- R1: After synchronous reset, `st_idle` is high, the other phase outputs are low, and all three enables are low.
- R2: In the idle phase, `sig_det` moves the controller to the synchronization window on the next cycle. `sof_hit`, `frame_end`, `loss_sync` and `reconf_req` have no effect while idle.
- R3: The window length is taken from `win_len` in the cycle `sig_det` is accepted. Without a start-of-frame, the window phase lasts exactly `win_len` cycles, with 0 treated as 1, and the controller is then idle again.
- R4: `sof_hit` in a window cycle other than the last moves the controller to the decoding phase on the next cycle.
- R5: When `sof_hit` arrives in the last window cycle, the timeout wins and the controller returns to idle. `sig_det` during the window neither reloads nor extends it.
- R6: On entry to the decoding phase, `en_decode` and `en_track` are high and `en_reconf` is low.
- R7: `reconf_req` in the decoding phase with no reconfiguration in progress raises `en_reconf` and lowers `en_decode` on the next cycle, while `en_track` stays high.
- R8: A reconfiguration stays in progress until `reconf_done`, which returns `en_decode` high on the next cycle. `reconf_done` beats a simultaneous `reconf_req`, and `reconf_req` while in progress has no effect.
- R9: `frame_end` in the decoding phase returns the controller to idle on the next cycle with all enables low. Any reconfiguration in progress is abandoned.
- R10: `loss_sync` in the decoding phase acts the same way as `frame_end`. It is ignored in the other phases.
- R11: Exactly one of `st_idle`, `st_presync` and `st_postsync` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_det | input | 1 | Incoming-signal strobe, for example a strength threshold crossing |
| sof_hit | input | 1 | Start-of-frame found by the synchronizer |
| win_len | input | WIN_W | Synchronization window length in cycles |
| frame_end | input | 1 | End of the received frame |
| loss_sync | input | 1 | Tracking has lost synchronization |
| reconf_req | input | 1 | Block-level reconfiguration request |
| reconf_done | input | 1 | Block-level reconfiguration finished |
| st_idle | output | 1 | Idle listening phase |
| st_presync | output | 1 | Synchronization window phase |
| st_postsync | output | 1 | Decoding phase |
| en_decode | output | 1 | Data decoding enable |
| en_track | output | 1 | Synchronization tracking enable |
| en_reconf | output | 1 | Reconfiguration in progress |

## Verification
Two pairs of functions can collide in one cycle. The first is a start-of-frame against window expiry. The second is a reconfiguration request or completion against frame end or loss of sync. Directed cases place `sof_hit` exactly on the last window cycle, including a one-cycle window and a zero window. Other directed cases raise `reconf_done` together with `reconf_req`, and `reconf_req` together with `frame_end`. Long random runs with short windows and dense strobes produce further collisions. A bench reference model judges every cycle against the stated priorities: timeout over start-of-frame, completion over request, and exit over any reconfiguration activity.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_POST = 2'd2
    } rx_phase_e;

    typedef struct packed {
        logic idle;
        logic pre;
        logic post;
    } phase_ind_t;

    typedef struct packed {
        logic decode;
        logic track;
        logic reconf;
    } act_en_t;

    function automatic phase_ind_t phase_decode(input rx_phase_e ph);
        phase_ind_t r;
        r.idle = (ph == PH_IDLE);
        r.pre  = (ph == PH_PRE);
        r.post = (ph == PH_POST);
        return r;
    endfunction

endpackage

// File: rtl/rxs_win_timer.sv
module rxs_win_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    logic [WIN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // A window of 0 behaves like a window of 1.
    assign expire = run && (cnt <= ONE);

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));  // R3

endmodule

// File: rtl/rxs_phase_fsm.sv
module rxs_phase_fsm
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_det,
    input  logic      sof_hit,
    input  logic      win_expire,
    input  logic      frame_end,
    input  logic      loss_sync,
    output rx_phase_e phase,
    output logic      win_load,
    output logic      post_leave
);
    rx_phase_e phase_nxt;

    assign win_load   = (phase == PH_IDLE) && sig_det;
    assign post_leave = (phase == PH_POST) && (frame_end || loss_sync);

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (sig_det) phase_nxt = PH_PRE;
            PH_PRE: begin
                if (win_expire)   phase_nxt = PH_IDLE;
                else if (sof_hit) phase_nxt = PH_POST;
            end
            PH_POST: if (frame_end || loss_sync) phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_decode(phase)));  // R11
    AST_TIMEOUT_WINS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE && win_expire) |=> (phase == PH_IDLE));  // R5
    AST_SOF_ENTER: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE && sof_hit && !win_expire) |=> (phase == PH_POST));  // R4
    AST_EXIT_POST: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_POST && (frame_end || loss_sync)) |=> (phase == PH_IDLE));  // R9
    AST_IDLE_DETECT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && sig_det) |=> (phase == PH_PRE));  // R2

endmodule

// File: rtl/rxs_reconf_ctl.sv
module rxs_reconf_ctl (
    input  logic clk,
    input  logic rst,
    input  logic in_post,
    input  logic leave,
    input  logic req,
    input  logic done,
    output logic busy
);
    logic busy_nxt;

    always_comb begin
        if (!in_post || leave) busy_nxt = 1'b0;
        else if (busy)         busy_nxt = !done;
        else                   busy_nxt = req;
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= 1'b0;
        else     busy <= busy_nxt;
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && in_post && !leave) |=> busy);  // R8
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);  // R8
    AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        leave |=> !busy);  // R9

endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
    import rxs_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_det,
    input  logic             sof_hit,
    input  logic [WIN_W-1:0] win_len,
    input  logic             frame_end,
    input  logic             loss_sync,
    input  logic             reconf_req,
    input  logic             reconf_done,
    output logic             st_idle,
    output logic             st_presync,
    output logic             st_postsync,
    output logic             en_decode,
    output logic             en_track,
    output logic             en_reconf
);
    rx_phase_e  phase;
    phase_ind_t ind;
    act_en_t    act;
    logic       win_load;
    logic       win_expire;
    logic       post_leave;
    logic       rc_busy;

    rxs_win_timer #(.WIN_W(WIN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (win_len),
        .run      (ind.pre),
        .expire   (win_expire)
    );

    rxs_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sig_det    (sig_det),
        .sof_hit    (sof_hit),
        .win_expire (win_expire),
        .frame_end  (frame_end),
        .loss_sync  (loss_sync),
        .phase      (phase),
        .win_load   (win_load),
        .post_leave (post_leave)
    );

    rxs_reconf_ctl u_reconf (
        .clk     (clk),
        .rst     (rst),
        .in_post (ind.post),
        .leave   (post_leave),
        .req     (reconf_req),
        .done    (reconf_done),
        .busy    (rc_busy)
    );

    assign ind = phase_decode(phase);

    always_comb begin
        act.track  = ind.post;
        act.reconf = ind.post && rc_busy;
        act.decode = ind.post && !rc_busy;
    end

    assign st_idle     = ind.idle;
    assign st_presync  = ind.pre;
    assign st_postsync = ind.post;
    assign en_decode   = act.decode;
    assign en_track    = act.track;
    assign en_reconf   = act.reconf;

    AST_DEC_PAUSED: assert property (@(posedge clk) disable iff (rst)
        en_reconf |-> (!en_decode && en_track));  // R7
    AST_EN_ONLY_POST: assert property (@(posedge clk) disable iff (rst)
        !st_postsync |-> !(en_decode || en_track || en_reconf));  // R9
    AST_ENTRY_DECODE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_postsync) |-> (en_decode && en_track && !en_reconf));  // R6

endmodule

// File: tb/sim_rx_frame_seq.sv
module sim_rx_frame_seq;
    localparam int WIN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_det = 0, sof_hit = 0, frame_end = 0, loss_sync = 0;
    logic reconf_req = 0, reconf_done = 0;
    logic [WIN_W-1:0] win_len = 16'd4;
    logic st_idle, st_presync, st_postsync, en_decode, en_track, en_reconf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 0;

    // reference model: 0 idle, 1 window, 2 decoding
    int m_ph = 0;
    int m_cnt = 0;
    bit m_busy = 0;

    always #2.5 clk = ~clk;

    rx_frame_seq #(.WIN_W(WIN_W)) u0 (
        .clk(clk), .rst(rst), .sig_det(sig_det), .sof_hit(sof_hit),
        .win_len(win_len), .frame_end(frame_end), .loss_sync(loss_sync),
        .reconf_req(reconf_req), .reconf_done(reconf_done),
        .st_idle(st_idle), .st_presync(st_presync), .st_postsync(st_postsync),
        .en_decode(en_decode), .en_track(en_track), .en_reconf(en_reconf)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic bit win_last(int c);
        return c <= 1;
    endfunction

    task automatic model_step();
        int nph = m_ph;
        bit nb = m_busy;
        case (m_ph)
            0: begin
                nb = 0;
                if (sig_det) begin nph = 1; m_cnt = int'(win_len); end
            end
            1: begin
                nb = 0;
                if (win_last(m_cnt)) nph = 0;
                else if (sof_hit) nph = 2;
                if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
            default: begin
                if (frame_end || loss_sync) begin nph = 0; nb = 0; end
                else if (m_busy) nb = !reconf_done;
                else nb = reconf_req;
            end
        endcase
        m_ph = nph;
        m_busy = nb;
    endtask

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_out();
        logic [5:0] e;
        e[5] = (m_ph == 0);
        e[4] = (m_ph == 1);
        e[3] = (m_ph == 2);
        e[2] = (m_ph == 2) && !m_busy;
        e[1] = (m_ph == 2);
        e[0] = (m_ph == 2) && m_busy;
        return e;
    endfunction

    function automatic logic [5:0] dut_out();
        return {st_idle, st_presync, st_postsync, en_decode, en_track, en_reconf};
    endfunction

    // drive at negedge, let the edge pass, check at next negedge
    task automatic step(string tag, bit sd, bit sf, bit fe, bit ls, bit rq, bit dn);
        sig_det = sd; sof_hit = sf; frame_end = fe; loss_sync = ls;
        reconf_req = rq; reconf_done = dn;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, dut_out(), exp_out());
    endtask

    task automatic idle_out(int n);
        for (int i = 0; i < n; i++) step("R1_quiet", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1", dut_out(), 6'b100000);
        rst = 0;

        // R2: strobes other than detect ignored while idle
        step("R2", 0, 1, 1, 1, 1, 1);
        step("R2", 1, 0, 0, 0, 0, 0);
        // R3: window of 4 expires
        win_len = 16'd4;
        for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 0, 0, 0);
        chk("R3_expired", dut_out(), 6'b100000);

        // R5: sof on the last window cycle loses; sig_det during window ignored
        win_len = 16'd3;
        step("R5", 1, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0);
        chk("R5_timeout_wins", dut_out(), 6'b100000);

        // one-cycle and zero windows
        win_len = 16'd1;
        step("R3", 1, 0, 0, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0);
        win_len = 16'd0;
        step("R3", 1, 0, 0, 0, 0, 0);
        step("R3_zero", 0, 0, 0, 0, 0, 0);

        // R4/R6: sof on first cycle of a 5 window
        win_len = 16'd5;
        step("R4", 1, 0, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0, 0);
        chk("R6", dut_out(), 6'b001110);
        // R7/R8 reconfiguration
        step("R7", 0, 0, 0, 0, 1, 0);
        chk("R7_paused", dut_out(), 6'b001011);
        step("R8_hold", 0, 0, 0, 0, 1, 0);
        step("R8_done_wins", 0, 0, 0, 0, 1, 1);
        chk("R8_resume", dut_out(), 6'b001110);
        step("R7", 0, 0, 0, 0, 1, 0);
        // R9: frame end while busy
        step("R9", 0, 0, 1, 0, 0, 0);
        chk("R9_idle", dut_out(), 6'b100000);

        // R10: loss of sync
        step("R10", 1, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 1, 1, 0);
        chk("R10_idle", dut_out(), 6'b100000);

        // random phase, fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            bit sd, sf, fe, ls, rq, dn;
            if (i % 200 == 0) win_len = WIN_W'($urandom_range(0, 12));
            sd = ($urandom_range(0, 3) == 0);
            sf = ($urandom_range(0, 4) == 0);
            fe = ($urandom_range(0, 15) == 0);
            ls = ($urandom_range(0, 20) == 0);
            rq = ($urandom_range(0, 5) == 0);
            dn = ($urandom_range(0, 4) == 0);
            step("R11_random", sd, sf, fe, ls, rq, dn);
        end
        idle_out(2);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule